// File: doc/BRIEF.md
# Front Panel Tray Controller

This block sits between the two front-panel keys of an optical drive, the tray position switches, and the playback engine. It turns debounced key presses and a software eject pulse into motor drive levels for the tray and single-cycle play, stop and skip commands. It also keeps the current audio track number, raises an error flag when the tray does not reach its end stop in time, and lights a busy indicator.

The open/close/stop key depends on playback state. While audio plays, a press only stops playback. With nothing playing, the same key moves the tray to its other end. The play/skip key starts an audio disc at track one, and while the disc plays it steps to the following track. At the last track it either wraps or stops, as a configuration input selects.

Top module: `panel_tray_ctrl`

## Requirements
- R1: Both keys are active low. They pass a two-flop synchronizer and are debounced. A level held for fewer than DEB_CYCLES cycles has no effect. Each press, taken on its debounced falling edge, issues exactly one command, and at most one of play_cmd, stop_cmd and skip_cmd is high in any cycle.
- R2: A play/skip press with the tray closed, nothing playing, audio_disc high and num_tracks nonzero pulses play_cmd, sets cur_track to 1 and raises playing.
- R3: A play/skip press while playing below the last track pulses skip_cmd and increments cur_track.
- R4: A play/skip press while playing at track num_tracks pulses skip_cmd and sets cur_track to 1 when wrap_en is high. When wrap_en is low it pulses stop_cmd, clears playing and keeps cur_track.
- R5: An open/close/stop press while playing pulses stop_cmd, clears playing and drives no tray motor. A further press then opens the tray.
- R6: With nothing playing, an open/close/stop press on a closed tray drives tray_open_drv, and on an open tray drives tray_close_drv.
- R7: A one-cycle sw_eject pulse acts exactly like an open/close/stop press, including stopping playback first.
- R8: tray_open_drv and tray_close_drv are never high together. Each drops as soon as its sensor reads low: tray_out_n for opening, tray_in_n for closing. Both sensors are active low.
- R9: If the tray sensor is not reached within MOVE_TIMEOUT cycles, the drive is released and tray_err is set. tray_err clears when the next tray motion starts.
- R10: A play/skip press has no effect when audio_disc is low or when the tray is open.
- R11: busy is high while either tray drive state is active, and whenever read_active is high.
- R12: After reset, no drive, command, playing or error output is high, and cur_track is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_play_n | input | 1 | Play/skip key, active low |
| key_stop_n | input | 1 | Open/close/stop key, active low |
| tray_in_n | input | 1 | Low when tray is closed |
| tray_out_n | input | 1 | Low when tray is fully open |
| sw_eject | input | 1 | Software eject pulse |
| audio_disc | input | 1 | High for an audio disc |
| num_tracks | input | TRK_W | Number of tracks on disc |
| wrap_en | input | 1 | Wrap to track 1 after last track |
| read_active | input | 1 | Data read in progress |
| tray_open_drv | output | 1 | Tray open motor drive |
| tray_close_drv | output | 1 | Tray close motor drive |
| play_cmd | output | 1 | Start playback pulse |
| stop_cmd | output | 1 | Stop playback pulse |
| skip_cmd | output | 1 | Next track pulse |
| playing | output | 1 | Playback active |
| cur_track | output | TRK_W | Current track |
| busy | output | 1 | Busy indicator |
| tray_err | output | 1 | Tray motion timeout flag |

## Verification
The state machine is driven through one long sequence of key presses, eject pulses and sensor arrivals. Runs of play presses walk past the last track once with wrap disabled and once with it enabled, which separates the stop outcome from the wrap outcome. Stop presses are given during playback, on a closed tray and on an open tray, so the two roles of that key can be told apart. A short key glitch and play presses with a data disc or an open tray show that these inputs are ignored. Directed steps leave the tray between its stops to force a timeout, and then show that the next motion clears the error.

// File: rtl/panel_tray_ctrl.sv
module panel_tray_ctrl #(
  parameter int DEB_CYCLES   = 8,
  parameter int MOVE_TIMEOUT = 1000,
  parameter int TRK_W        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_play_n,
  input  logic             key_stop_n,
  input  logic             tray_in_n,
  input  logic             tray_out_n,
  input  logic             sw_eject,
  input  logic             audio_disc,
  input  logic [TRK_W-1:0] num_tracks,
  input  logic             wrap_en,
  input  logic             read_active,
  output logic             tray_open_drv,
  output logic             tray_close_drv,
  output logic             play_cmd,
  output logic             stop_cmd,
  output logic             skip_cmd,
  output logic             playing,
  output logic [TRK_W-1:0] cur_track,
  output logic             busy,
  output logic             tray_err
);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam int MW = $clog2(MOVE_TIMEOUT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PLAY, ST_OPENING, ST_OPEN, ST_CLOSING} st_t;
  st_t st;

  logic [1:0] key_s1, key_s2, key_stb, key_hit;
  logic [DW-1:0] deb_cnt [2];
  logic [MW-1:0] mcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      key_s1 <= 2'b11;
      key_s2 <= 2'b11;
    end else begin
      key_s1 <= {key_stop_n, key_play_n};
      key_s2 <= key_s1;
    end

  for (genvar g = 0; g < 2; g++) begin : g_deb
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        key_stb[g] <= 1'b1;
        deb_cnt[g] <= '0;
        key_hit[g] <= 1'b0;
      end else begin
        key_hit[g] <= 1'b0;
        if (key_s2[g] != key_stb[g]) begin
          if (deb_cnt[g] == DW'(DEB_CYCLES - 1)) begin
            key_stb[g] <= key_s2[g];
            deb_cnt[g] <= '0;
            key_hit[g] <= ~key_s2[g];
          end else
            deb_cnt[g] <= deb_cnt[g] + 1'b1;
        end else
          deb_cnt[g] <= '0;
      end
  end

  wire play_ev  = key_hit[0];
  wire stop_ev  = key_hit[1] | sw_eject;
  wire last_trk = cur_track >= num_tracks;
  wire mtimeout = mcnt == MW'(MOVE_TIMEOUT - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_track <= '0;
      mcnt      <= '0;
      tray_err  <= 1'b0;
      play_cmd  <= 1'b0;
      stop_cmd  <= 1'b0;
      skip_cmd  <= 1'b0;
    end else begin
      play_cmd <= 1'b0;
      stop_cmd <= 1'b0;
      skip_cmd <= 1'b0;
      case (st)
        ST_IDLE:
          if (stop_ev) begin
            st       <= ST_OPENING;
            mcnt     <= '0;
            tray_err <= 1'b0;
          end else if (play_ev && audio_disc && num_tracks != '0) begin
            st        <= ST_PLAY;
            cur_track <= TRK_W'(1);
            play_cmd  <= 1'b1;
          end
        ST_PLAY:
          if (stop_ev) begin
            st       <= ST_IDLE;
            stop_cmd <= 1'b1;
          end else if (play_ev) begin
            if (!last_trk) begin
              cur_track <= cur_track + 1'b1;
              skip_cmd  <= 1'b1;
            end else if (wrap_en) begin
              cur_track <= TRK_W'(1);
              skip_cmd  <= 1'b1;
            end else begin
              st       <= ST_IDLE;
              stop_cmd <= 1'b1;
            end
          end
        ST_OPENING:
          if (!tray_out_n) st <= ST_OPEN;
          else if (mtimeout) begin
            st       <= ST_OPEN;
            tray_err <= 1'b1;
          end else mcnt <= mcnt + 1'b1;
        ST_OPEN:
          if (stop_ev) begin
            st       <= ST_CLOSING;
            mcnt     <= '0;
            tray_err <= 1'b0;
          end
        ST_CLOSING:
          if (!tray_in_n) st <= ST_IDLE;
          else if (mtimeout) begin
            st       <= ST_IDLE;
            tray_err <= 1'b1;
          end else mcnt <= mcnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end

  assign tray_open_drv  = (st == ST_OPENING) && tray_out_n;
  assign tray_close_drv = (st == ST_CLOSING) && tray_in_n;
  assign playing        = st == ST_PLAY;
  assign busy           = st == ST_OPENING || st == ST_CLOSING || read_active;
endmodule

// File: rtl/panel_tray_ctrl_chk.sv
module panel_tray_ctrl_chk #(
  parameter int TRK_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             audio_disc,
  input logic             read_active,
  input logic             tray_open_drv,
  input logic             tray_close_drv,
  input logic             play_cmd,
  input logic             stop_cmd,
  input logic             skip_cmd,
  input logic             playing,
  input logic [TRK_W-1:0] cur_track,
  input logic             busy,
  input logic             tray_err
);
  // R8
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tray_open_drv && tray_close_drv));
  // R1
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({play_cmd, stop_cmd, skip_cmd}));
  // R2
  play_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_cmd |-> (cur_track == TRK_W'(1)) && playing);
  // R3
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_cmd |-> (cur_track == $past(cur_track) + 1'b1) || (cur_track == TRK_W'(1)));
  // R5
  stop_no_motion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |-> !playing && !tray_open_drv && !tray_close_drv);
  // R9
  err_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tray_err) |-> $past(tray_open_drv || tray_close_drv));
  // R10
  play_audio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_cmd |-> $past(audio_disc));
  // R11
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_active |-> busy);
endmodule

bind panel_tray_ctrl panel_tray_ctrl_chk #(.TRK_W(TRK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .audio_disc(audio_disc), .read_active(read_active),
  .tray_open_drv(tray_open_drv), .tray_close_drv(tray_close_drv),
  .play_cmd(play_cmd), .stop_cmd(stop_cmd), .skip_cmd(skip_cmd),
  .playing(playing), .cur_track(cur_track), .busy(busy), .tray_err(tray_err)
);

// File: tb/test_panel_tray_ctrl.sv
module test_panel_tray_ctrl;
  localparam int PERIOD  = 10;
  localparam int DEB     = 4;
  localparam int TMO     = 40;
  localparam int TW      = 7;

  localparam logic [2:0] OP_PLAY = 3'd0, OP_STOP = 3'd1, OP_EJ = 3'd2,
                         OP_OPN  = 3'd3, OP_CLS  = 3'd4, OP_GL = 3'd5;

  typedef struct packed {
    logic [2:0] op; logic audio; logic wrap;
    logic pl; logic [6:0] trk; logic opn; logic cls;
    logic [1:0] dp; logic [1:0] ds; logic [1:0] dk;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{OP_GL,   1,0, 0,7'd0, 0,0, 2'd0,2'd0,2'd0},  // R1 glitch
    '{OP_PLAY, 1,0, 1,7'd1, 0,0, 2'd1,2'd0,2'd0},  // R2
    '{OP_PLAY, 1,0, 1,7'd2, 0,0, 2'd0,2'd0,2'd1},  // R3
    '{OP_PLAY, 1,0, 1,7'd3, 0,0, 2'd0,2'd0,2'd1},  // R3
    '{OP_PLAY, 1,0, 0,7'd3, 0,0, 2'd0,2'd1,2'd0},  // R4 no wrap
    '{OP_PLAY, 1,0, 1,7'd1, 0,0, 2'd1,2'd0,2'd0},  // R2
    '{OP_PLAY, 1,0, 1,7'd2, 0,0, 2'd0,2'd0,2'd1},
    '{OP_PLAY, 1,0, 1,7'd3, 0,0, 2'd0,2'd0,2'd1},
    '{OP_PLAY, 1,1, 1,7'd1, 0,0, 2'd0,2'd0,2'd1},  // R4 wrap
    '{OP_STOP, 1,1, 0,7'd1, 0,0, 2'd0,2'd1,2'd0},  // R5
    '{OP_STOP, 1,1, 0,7'd1, 1,0, 2'd0,2'd0,2'd0},  // R5 R6
    '{OP_OPN,  1,1, 0,7'd1, 0,0, 2'd0,2'd0,2'd0},  // R8
    '{OP_PLAY, 1,1, 0,7'd1, 0,0, 2'd0,2'd0,2'd0},  // R10 tray open
    '{OP_STOP, 1,1, 0,7'd1, 0,1, 2'd0,2'd0,2'd0},  // R6
    '{OP_CLS,  1,1, 0,7'd1, 0,0, 2'd0,2'd0,2'd0},  // R8
    '{OP_PLAY, 0,1, 0,7'd1, 0,0, 2'd0,2'd0,2'd0},  // R10 data disc
    '{OP_EJ,   0,1, 0,7'd1, 1,0, 2'd0,2'd0,2'd0},  // R7
    '{OP_OPN,  0,1, 0,7'd1, 0,0, 2'd0,2'd0,2'd0},
    '{OP_EJ,   0,1, 0,7'd1, 0,1, 2'd0,2'd0,2'd0},  // R7
    '{OP_CLS,  0,1, 0,7'd1, 0,0, 2'd0,2'd0,2'd0}
  };

  logic clk = 0, rst_n = 0;
  logic key_play_n = 1, key_stop_n = 1, tray_in_n = 0, tray_out_n = 1;
  logic sw_eject = 0, audio_disc = 1, wrap_en = 0, read_active = 0;
  logic [TW-1:0] num_tracks = 7'd3;
  logic tray_open_drv, tray_close_drv, play_cmd, stop_cmd, skip_cmd, playing, busy, tray_err;
  logic [TW-1:0] cur_track;

  int checks = 0, errors = 0;
  int n_play = 0, n_stop = 0, n_skip = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  panel_tray_ctrl #(.DEB_CYCLES(DEB), .MOVE_TIMEOUT(TMO), .TRK_W(TW)) i_panel_tray_ctrl (
    .clk, .rst_n, .key_play_n, .key_stop_n, .tray_in_n, .tray_out_n, .sw_eject,
    .audio_disc, .num_tracks, .wrap_en, .read_active, .tray_open_drv, .tray_close_drv,
    .play_cmd, .stop_cmd, .skip_cmd, .playing, .cur_track, .busy, .tray_err);

  always @(posedge clk) begin
    if (play_cmd) n_play++;
    if (stop_cmd) n_stop++;
    if (skip_cmd) n_skip++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input bit stop_key, input int low_cyc);
    if (stop_key) key_stop_n = 0; else key_play_n = 0;
    wait_cyc(low_cyc);
    key_stop_n = 1; key_play_n = 1;
    wait_cyc(DEB + 4);
  endtask

  task automatic eject();
    sw_eject = 1; wait_cyc(1); sw_eject = 0; wait_cyc(4);
  endtask

  task automatic do_op(input logic [2:0] op);
    case (op)
      OP_PLAY: press(0, DEB + 4);
      OP_STOP: press(1, DEB + 4);
      OP_GL:   press(0, DEB - 2);
      OP_EJ:   eject();
      OP_OPN:  begin tray_in_n = 1; tray_out_n = 0; wait_cyc(3); end
      OP_CLS:  begin tray_in_n = 0; tray_out_n = 1; wait_cyc(3); end
      default: wait_cyc(1);
    endcase
  endtask

  initial begin
    wait_cyc(3);
    // R12 reset state
    check("R12", {tray_open_drv, tray_close_drv, play_cmd, stop_cmd, skip_cmd, playing, tray_err, busy}, 0);
    check("R12 track", cur_track, 0);
    rst_n = 1;
    wait_cyc(2);

    for (int v = 0; v < 20; v++) begin
      int p0, s0, k0;
      p0 = n_play; s0 = n_stop; k0 = n_skip;
      audio_disc = VEC[v].audio; wrap_en = VEC[v].wrap;
      do_op(VEC[v].op);
      check($sformatf("R1-table row %0d", v),
            {playing, cur_track, tray_open_drv, tray_close_drv,
             2'(n_play - p0), 2'(n_stop - s0), 2'(n_skip - k0)},
            {VEC[v].pl, VEC[v].trk, VEC[v].opn, VEC[v].cls, VEC[v].dp, VEC[v].ds, VEC[v].dk});
    end

    // R7 eject while playing only stops
    audio_disc = 1;
    press(0, DEB + 4);
    check("R2 replay", playing, 1);
    begin
      int s0; s0 = n_stop;
      eject();
      check("R7 stop first", {playing, tray_open_drv, 2'(n_stop - s0)}, {1'b0, 1'b0, 2'd1});
    end

    // R9 timeout with tray stuck between stops
    tray_in_n = 1; tray_out_n = 1;
    press(1, DEB + 4);
    check("R6 opening", tray_open_drv, 1);
    check("R11 busy moving", busy, 1);
    wait_cyc(TMO + 20);
    check("R9 drive released", tray_open_drv, 0);
    check("R9 err set", tray_err, 1);
    press(1, DEB + 4);
    check("R9 err cleared", {tray_err, tray_close_drv}, 2'b01);
    check("R8 no open", tray_open_drv, 0);
    tray_in_n = 0; wait_cyc(3);
    check("R8 close released", {tray_close_drv, busy}, 2'b00);
    read_active = 1; wait_cyc(1);
    check("R11 read busy", busy, 1);
    read_active = 0; wait_cyc(1);
    check("R11 idle", busy, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule